// File: doc/BRIEF.md
# Flat Page Table Address Translator

This block turns a 32-bit I/O virtual address into a physical address by reading one entry from a single-level page table in memory. The table covers the whole 4 GiB virtual space at 4 KiB granularity. Each entry is one 32-bit word, so the table is 2^20 words (4 MiB) long. A client presents a virtual address on a valid/ready request port. The block computes where the matching entry lives, reads that entry through a simple memory read port, and inspects it. It then returns the physical address on a valid/ready response port.

An entry whose valid flag is clear does not stall the access. The block marks the response as a fault and points the access at a protect buffer, so the client's transfer still lands somewhere harmless. It also keeps the page-aligned faulting virtual address for later inspection. A fault carries no read/write distinction; every fault is reported the same way.

Only one lookup is in flight at a time. The table base input may change at any moment. Its value is taken when a request is accepted, so a change affects the next lookup and never the one already running.

Top module: `flat_iova_xlate`

## Requirements
- R1: After reset, `req_ready_o` is 1, `mem_req_valid_o` is 0, `rsp_valid_o` is 0 and `flt_va_o` is 0.
- R2: The entry read address on `mem_addr_o` is the table base plus four times the virtual page number (virtual address bits 31:12), wrapping modulo 2^32.
- R3: When the entry has bit 1 (valid) set, the response has `rsp_fault_o` = 0 and `rsp_pa_o` = entry bits 31:12 followed by virtual address bits 11:0.
- R4: `rsp_nonsec_o` equals entry bit 3 on a valid entry and is 0 on a fault.
- R5: When entry bit 1 is clear, the response has `rsp_fault_o` = 1 and `rsp_pa_o` = `prot_addr_i` with bits 6:0 forced to zero (128-byte aligned), whatever the other entry bits hold.
- R6: A fault loads `flt_va_o` with the virtual address with bits 11:0 cleared, in the same cycle the response appears. Lookups with a valid entry leave `flt_va_o` unchanged.
- R7: From request acceptance until the response handshake, `req_ready_o` is 0 and further requests are not taken.
- R8: The table base is sampled at request acceptance. A change to `tbl_base_i` during a lookup does not move `mem_addr_o`, and the next lookup uses the new value.
- R9: While `mem_req_ready_i` is low, `mem_req_valid_o` stays 1 and `mem_addr_o` stays stable.
- R10: While `rsp_ready_i` is low, `rsp_valid_o` stays 1 and the response payload stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_base_i | input | 32 | Page table base address |
| prot_addr_i | input | 32 | Protect buffer address used on a fault |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Block can accept a lookup |
| req_iova_i | input | 32 | Virtual address to translate |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Entry data valid |
| mem_rsp_data_i | input | 32 | Entry data |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Client accepts the result |
| rsp_pa_o | output | 32 | Physical address (protect address on a fault) |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_nonsec_o | output | 1 | Non-secure flag from the entry |
| flt_va_o | output | 32 | Page-aligned virtual address of the last fault |

## Verification
The entry read request is due one cycle after the request handshake. Once the memory returns the entry, the response and the fault address record are due exactly one cycle later. The port is ready again one cycle after the response handshake. The bench drives every input on the falling edge. It counts rising edges from each handshake and samples each result on the falling edge of the cycle in which it is due. It also checks that the response is still low one cycle earlier. Memory and response stalls of zero to two cycles are inserted so that the hold behaviour is sampled on every stalled cycle.

// File: rtl/flat_iova_xlate.sv
module flat_iova_xlate #(
  parameter int AW        = 32,
  parameter int PG_SHIFT  = 12,
  parameter int PROT_ALN  = 7,
  parameter int ENT_LOG2  = 2,
  parameter int VLD_BIT   = 1,
  parameter int NS_BIT    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] tbl_base_i,
  input  logic [AW-1:0] prot_addr_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_iova_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [AW-1:0] mem_rsp_data_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [AW-1:0] rsp_pa_o,
  output logic          rsp_fault_o,
  output logic          rsp_nonsec_o,
  output logic [AW-1:0] flt_va_o
);
  localparam int VPN_W = AW - PG_SHIFT;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_RESP} st_t;
  st_t st;

  logic [AW-1:0] iova_q, base_q;
  logic          unused_bits;

  assign req_ready_o     = (st == S_IDLE);
  assign mem_req_valid_o = (st == S_FETCH);
  assign rsp_valid_o     = (st == S_RESP);
  assign mem_addr_o      = base_q + (AW'(iova_q[AW-1:PG_SHIFT]) << ENT_LOG2);
  assign unused_bits     = ^{mem_rsp_data_i, prot_addr_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      iova_q       <= '0;
      base_q       <= '0;
      rsp_pa_o     <= '0;
      rsp_fault_o  <= 1'b0;
      rsp_nonsec_o <= 1'b0;
      flt_va_o     <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid_i) begin
          iova_q <= req_iova_i;
          base_q <= tbl_base_i;
          st     <= S_FETCH;
        end
        S_FETCH: if (mem_req_ready_i) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid_i) begin
          st <= S_RESP;
          if (mem_rsp_data_i[VLD_BIT]) begin
            rsp_pa_o     <= {mem_rsp_data_i[AW-1:PG_SHIFT], iova_q[PG_SHIFT-1:0]};
            rsp_fault_o  <= 1'b0;
            rsp_nonsec_o <= mem_rsp_data_i[NS_BIT];
          end else begin
            rsp_pa_o     <= {prot_addr_i[AW-1:PROT_ALN], {PROT_ALN{1'b0}}};
            rsp_fault_o  <= 1'b1;
            rsp_nonsec_o <= 1'b0;
            flt_va_o     <= {iova_q[AW-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
          end
        end
        S_RESP: if (rsp_ready_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> (!mem_req_valid_o && !rsp_valid_o));

  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_fault_o) && $stable(rsp_nonsec_o)));

  a_r6_fva_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_va_o) |-> (rsp_valid_o && rsp_fault_o));

  a_r6_fva_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    flt_va_o[PG_SHIFT-1:0] == '0);

  a_r5_prot_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_o[PROT_ALN-1:0] == '0 && !rsp_nonsec_o));
endmodule

// File: tb/tb_flat_iova_xlate.sv
`timescale 1ns/1ps
module tb_flat_iova_xlate;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] tbl_base = '0, prot_addr = 32'h0008_0FFF, req_iova = '0, mem_data = '0;
  logic        req_valid = 0, mem_ready = 0, mem_rvalid = 0, rsp_ready = 0;
  logic        req_ready, mem_valid, rsp_valid, rsp_fault, rsp_ns;
  logic [31:0] mem_addr, rsp_pa, flt_va;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_fva = '0;

  localparam logic [31:0] PROT_EXP = 32'h0008_0F80;

  flat_iova_xlate dut (
    .clk(clk), .rst_n(rst_n), .tbl_base_i(tbl_base), .prot_addr_i(prot_addr),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_iova_i(req_iova),
    .mem_req_valid_o(mem_valid), .mem_req_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(mem_rvalid), .mem_rsp_data_i(mem_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_pa_o(rsp_pa),
    .rsp_fault_o(rsp_fault), .rsp_nonsec_o(rsp_ns), .flt_va_o(flt_va));

  always #2.5 clk = ~clk;

  // {table base, virtual address, entry, expected physical address}
  localparam logic [127:0] VEC [8] = '{
    {32'h0010_0000, 32'h1234_5678, 32'hABCD_E00A, 32'hABCD_E678},
    {32'h8000_0000, 32'h0000_0FFF, 32'h0000_1002, 32'h0000_1FFF},
    {32'h0040_0000, 32'hFFFF_F000, 32'hFFFF_F00A, 32'hFFFF_F000},
    {32'h0010_0000, 32'hDEAD_BEEF, 32'h1234_5008, PROT_EXP},
    {32'hFFC0_0000, 32'hFFFF_FABC, 32'h0000_000A, 32'h0000_0ABC},
    {32'h0000_0000, 32'h0000_1FFF, 32'h0000_0000, PROT_EXP},
    {32'hFFFF_FFF0, 32'h0000_8000, 32'h7777_7FFE, 32'h7777_7000},
    {32'h0000_0000, 32'h4000_0123, 32'hFFFF_FFFD, PROT_EXP}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] b, input logic [31:0] va, input logic [31:0] ent,
                        input logic [31:0] pa, input int mstall, input int rstall);
    logic [31:0] ea = b + {va[31:12], 2'b00};
    logic        flt = ~ent[1];
    logic        ns  = ent[1] & ent[3];
    @(negedge clk);
    tbl_base = b; req_iova = va; req_valid = 1;
    chk("R7 ready before accept", 32'(req_ready), 1);
    @(posedge clk); @(negedge clk);
    tbl_base = b ^ 32'h5A5A_0000;            // R8: change after accept
    req_iova = va ^ 32'hFFFF_F000;           // R7: second request held pending
    chk("R7 busy after accept", 32'(req_ready), 0);
    chk("R9 mem request valid", 32'(mem_valid), 1);
    chk("R2 R8 entry address", mem_addr, ea);
    for (int k = 0; k < mstall; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R9 mem request held", 32'(mem_valid), 1);
      chk("R9 R8 address stable", mem_addr, ea);
    end
    mem_ready = 1;
    @(posedge clk); @(negedge clk);
    mem_ready = 0; mem_rvalid = 1; mem_data = ent;
    chk("R7 mem request dropped", 32'(mem_valid), 0);
    chk("R10 no early response", 32'(rsp_valid), 0);
    @(posedge clk); @(negedge clk);
    mem_rvalid = 0; mem_data = '0;
    if (flt) exp_fva = {va[31:12], 12'h000};
    chk("R10 response valid", 32'(rsp_valid), 1);
    chk(flt ? "R5 fault pa" : "R3 pa", rsp_pa, pa);
    chk(flt ? "R5 fault flag" : "R3 fault flag", 32'(rsp_fault), 32'(flt));
    chk("R4 nonsec", 32'(rsp_ns), 32'(ns));
    chk("R6 fault va", flt_va, exp_fva);
    chk("R7 busy in response", 32'(req_ready), 0);
    for (int k = 0; k < rstall; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R10 response held", 32'(rsp_valid), 1);
      chk("R10 pa stable", rsp_pa, pa);
      chk("R10 fault stable", 32'(rsp_fault), 32'(flt));
    end
    req_valid = 0; rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    rsp_ready = 0;
    chk("R7 ready after response", 32'(req_ready), 1);
    chk("R10 response cleared", 32'(rsp_valid), 0);
    chk("R6 fault va kept", flt_va, exp_fva);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req_ready", 32'(req_ready), 1);
    chk("R1 mem_req_valid", 32'(mem_valid), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 flt_va", flt_va, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after release", 32'(mem_valid), 0);

    for (int i = 0; i < 8; i++)
      lookup(VEC[i][127:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], i % 3, (i + 1) % 3);

    // R8: back-to-back lookups of one page with different bases
    lookup(32'h0000_1000, 32'h0000_3000, 32'h0005_0002, 32'h0005_0000, 0, 0);
    lookup(32'h0000_2000, 32'h0000_3000, 32'h0006_000A, 32'h0006_0000, 0, 0);
    // R6: fault with long stalls, then a valid entry that must not touch the record
    lookup(32'h0020_0000, 32'hFFFF_FFFF, 32'hFFFF_F009, PROT_EXP, 2, 2);
    lookup(32'h0020_0000, 32'h0000_0001, 32'h1000_0002, 32'h1000_0001, 1, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule